// File: doc/BRIEF.md
# VME Single-Cycle Slave Responder

This block is the slave side of a VME board interface. It handles single-cycle data transfers only. It watches the incoming bus strobes, the address modifier and the address lines. When a cycle targets the board, it works out which byte lanes the master selected. A read is served from a local word-wide register port and the result is driven onto the data lines. A write merges the bus data into a local word. The cycle ends with an acknowledge, or with a bus error when the lane selection is not legal.

The strobes are asynchronous to the local clock, so they pass through a synchronizer chain of `SYNC_STAGES` flip-flops. The address phase is captured when the synchronized address strobe falls. The byte-lane code is sampled one settle cycle after the first data strobe is seen. The lines that would be open-drain or tri-state on a real backplane are modelled as separate signals:
- `vme_dtack_low` and `vme_berr_low` are pull-low requests.
- `vme_data_o` carries read data, qualified by `vme_data_oe`.

The local register port has zero read latency. `reg_rdata` must be valid in the same cycle as the one-cycle `reg_req` pulse.

Top module: `vme_slave_responder`

## Requirements
- R1: Only address modifiers 0x09 (32-bit space), 0x39 (24-bit space) and 0x29 (16-bit space) are served. Any other modifier, including block-transfer codes 0x0B/0x3B and 64-bit block codes 0x08/0x38, produces no acknowledge, no bus error and no `reg_req`.
- R2: A cycle hits only when the address bits from `WIN_BITS` up to the top of the selected space equal the matching `BASE_*` parameter. The top of the space is bit 31, 23 or 15. Lines above the 24-bit or 16-bit space are ignored.
- R3: The local word index is address bits `WIN_BITS-1:2`. Address bit 1 and the long-word line never change the index.
- R4: The lane code {ds_n[1], ds_n[0], addr[1], lword_n} selects local bytes, where byte 0 is bits 31:24 and byte 3 is bits 7:0. The legal codes are:
  - 0101 selects byte 0.
  - 1001 selects byte 1.
  - 0111 selects byte 2.
  - 1011 selects byte 3.
  - 0001 selects bytes 0-1.
  - 0011 selects bytes 2-3.
  - 0000 selects all four bytes.
  
  `reg_be` bit 3 enables byte 0 and bit 0 enables byte 3.
- R5: Read data placement on the bus:
  - Bytes 0 and 2 appear on data bits 15:8.
  - Bytes 1 and 3 appear on data bits 7:0.
  - A 16-bit pair appears on bits 15:0.
  - A full word appears on bits 31:0.
  - Unused data bits are driven 0.
- R6: A write takes the selected bytes from those same bus positions and leaves the unselected local bytes unchanged.
- R7: A hit with any other lane code raises `vme_berr_low` 4 clock edges after the strobes change and issues no `reg_req`.
- R8: A legal hit raises `vme_dtack_low` 5 clock edges after the data strobes go low. On reads, `vme_data_oe` and valid data appear in the same cycle. The acknowledge and the bus error are never both active.
- R9: Acknowledge, bus error and data drive are released 3 clock edges after both data strobes return high.
- R10: Every served cycle issues exactly one single-cycle `reg_req`. `reg_rdata` is taken in that cycle.
- R11: While reset is held, no acknowledge, bus error, data drive or `reg_req` is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vme_as_n | input | 1 | Address strobe, active low |
| vme_ds_n | input | 2 | Data strobes {upper, lower}, active low |
| vme_write_n | input | 1 | Low for write, high for read |
| vme_lword_n | input | 1 | Long-word line, part of the lane code |
| vme_am | input | 6 | Address modifier |
| vme_addr | input | 31 | Address lines 31:1 |
| vme_data_i | input | 32 | Data lines as seen from the bus |
| vme_data_o | output | 32 | Read data toward the bus |
| vme_data_oe | output | 1 | Read data drive enable |
| vme_dtack_low | output | 1 | Request to pull the acknowledge line low |
| vme_berr_low | output | 1 | Request to pull the bus error line low |
| reg_req | output | 1 | One-cycle local access strobe |
| reg_we | output | 1 | Local access is a write |
| reg_idx | output | WIN_BITS-2 | Local word index |
| reg_be | output | 4 | Local byte enables |
| reg_wdata | output | 32 | Local write word |
| reg_rdata | input | 32 | Local read word, valid during reg_req |

## Verification
Each result has a fixed delay, counted in rising clock edges after the bench changes the strobes on a falling edge:
- The bus error is due after 4 edges.
- The acknowledge and the read data are due after 5 edges.
- The release is due after 3 edges of both data strobes being high.

The bench counts falling edges until the response appears and compares that count against these exact figures, so both early and late answers are caught. A cycle that is not served gets a 12-cycle observation window in which neither response may appear and the local strobe count must not move. Written data is checked by reading the word back with a full-width access and comparing it against a shadow copy that bench functions merge from the lane table.

// File: rtl/vme_resp_pkg.sv
package vme_resp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_DS,
    ST_SETTLE,
    ST_REQ,
    ST_ACK,
    ST_ERR
  } resp_state_e;

  typedef struct packed {
    logic       legal;
    logic [3:0] be;
  } lane_t;

  localparam logic [5:0] AM_SGL_32 = 6'h09;
  localparam logic [5:0] AM_SGL_24 = 6'h39;
  localparam logic [5:0] AM_SGL_16 = 6'h29;

endpackage

// File: rtl/vme_in_sync.sv
module vme_in_sync #(
  parameter int               WIDTH     = 3,
  parameter int               STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= RESET_VAL;
        else        stage_q[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= RESET_VAL;
        else        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/vme_addr_match.sv
module vme_addr_match
  import vme_resp_pkg::*;
#(
  parameter int          WIN_BITS = 8,
  parameter logic [15:0] BASE_A16 = 16'hC300,
  parameter logic [23:0] BASE_A24 = 24'h5A_0000,
  parameter logic [31:0] BASE_A32 = 32'h4200_0000
) (
  input  logic [5:0]  am,
  input  logic [31:2] addr,
  output logic        hit
);

  logic m32, m24, m16;

  always_comb begin
    m32 = (addr[31:WIN_BITS] == BASE_A32[31:WIN_BITS]);
    m24 = (addr[23:WIN_BITS] == BASE_A24[23:WIN_BITS]);
    m16 = (addr[15:WIN_BITS] == BASE_A16[15:WIN_BITS]);
    case (am)
      AM_SGL_32: hit = m32;
      AM_SGL_24: hit = m24;
      AM_SGL_16: hit = m16;
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/vme_lane_map.sv
module vme_lane_map
  import vme_resp_pkg::*;
(
  input  logic [3:0]  code,
  input  logic [31:0] bus_wr,
  input  logic [31:0] word_rd,
  output lane_t       lane,
  output logic [31:0] word_wr,
  output logic [31:0] bus_rd
);

  always_comb begin
    lane    = '0;
    word_wr = '0;
    bus_rd  = '0;
    case (code)
      4'b0101: begin
        lane            = '{legal: 1'b1, be: 4'b1000};
        word_wr[31:24]  = bus_wr[15:8];
        bus_rd[15:8]    = word_rd[31:24];
      end
      4'b1001: begin
        lane            = '{legal: 1'b1, be: 4'b0100};
        word_wr[23:16]  = bus_wr[7:0];
        bus_rd[7:0]     = word_rd[23:16];
      end
      4'b0111: begin
        lane            = '{legal: 1'b1, be: 4'b0010};
        word_wr[15:8]   = bus_wr[15:8];
        bus_rd[15:8]    = word_rd[15:8];
      end
      4'b1011: begin
        lane            = '{legal: 1'b1, be: 4'b0001};
        word_wr[7:0]    = bus_wr[7:0];
        bus_rd[7:0]     = word_rd[7:0];
      end
      4'b0001: begin
        lane            = '{legal: 1'b1, be: 4'b1100};
        word_wr[31:16]  = bus_wr[15:0];
        bus_rd[15:0]    = word_rd[31:16];
      end
      4'b0011: begin
        lane            = '{legal: 1'b1, be: 4'b0011};
        word_wr[15:0]   = bus_wr[15:0];
        bus_rd[15:0]    = word_rd[15:0];
      end
      4'b0000: begin
        lane            = '{legal: 1'b1, be: 4'b1111};
        word_wr         = bus_wr;
        bus_rd          = word_rd;
      end
      default: lane = '0;
    endcase
  end

endmodule

// File: rtl/vme_slave_responder.sv
module vme_slave_responder
  import vme_resp_pkg::*;
#(
  parameter int          WIN_BITS    = 8,
  parameter logic [15:0] BASE_A16    = 16'hC300,
  parameter logic [23:0] BASE_A24    = 24'h5A_0000,
  parameter logic [31:0] BASE_A32    = 32'h4200_0000,
  parameter int          SYNC_STAGES = 2,
  localparam int         IDX_W       = WIN_BITS - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vme_as_n,
  input  logic [1:0]       vme_ds_n,
  input  logic             vme_write_n,
  input  logic             vme_lword_n,
  input  logic [5:0]       vme_am,
  input  logic [31:1]      vme_addr,
  input  logic [31:0]      vme_data_i,
  output logic [31:0]      vme_data_o,
  output logic             vme_data_oe,
  output logic             vme_dtack_low,
  output logic             vme_berr_low,
  output logic             reg_req,
  output logic             reg_we,
  output logic [IDX_W-1:0] reg_idx,
  output logic [3:0]       reg_be,
  output logic [31:0]      reg_wdata,
  input  logic [31:0]      reg_rdata
);

  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // strobe synchronizer
  logic [2:0] strb_s;
  logic       as_s;
  logic [1:0] ds_s;

  vme_in_sync #(
    .WIDTH    (3),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(3'b111)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d    ({vme_as_n, vme_ds_n}),
    .q    (strb_s)
  );

  assign as_s = strb_s[2];
  assign ds_s = strb_s[1:0];

  // address decode on live lines (stable before the strobe)
  logic addr_hit;

  vme_addr_match #(
    .WIN_BITS(WIN_BITS),
    .BASE_A16(BASE_A16),
    .BASE_A24(BASE_A24),
    .BASE_A32(BASE_A32)
  ) u_match (
    .am  (vme_am),
    .addr(vme_addr[31:2]),
    .hit (addr_hit)
  );

  // state and captured cycle context
  resp_state_e      state_q, state_d;
  logic             as_prev_q;
  logic [IDX_W-1:0] idx_q;
  logic             write_q, a1_q, lword_q;
  logic [5:0]       am_q;
  logic [3:0]       code_q;
  logic [31:0]      wbus_q, rd_q;

  logic             as_fall;
  logic             hdr_le, code_le, rd_le;
  logic [3:0]       code_sel;
  lane_t            lane;
  logic [31:0]      word_wr, bus_rd;

  assign as_fall  = as_prev_q & ~as_s;
  assign hdr_le   = (state_q == ST_IDLE) && as_fall;
  assign code_le  = (state_q == ST_SETTLE);
  assign rd_le    = (state_q == ST_REQ) && !write_q;
  assign code_sel = (state_q == ST_SETTLE) ? {ds_s, a1_q, lword_q} : code_q;

  vme_lane_map u_lane (
    .code   (code_sel),
    .bus_wr (wbus_q),
    .word_rd(rd_q),
    .lane   (lane),
    .word_wr(word_wr),
    .bus_rd (bus_rd)
  );

  // next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (as_fall && addr_hit) state_d = ST_WAIT_DS;
      ST_WAIT_DS: begin
        if (as_s)                 state_d = ST_IDLE;
        else if (ds_s != 2'b11)   state_d = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (as_s)                 state_d = ST_IDLE;
        else if (ds_s == 2'b11)   state_d = ST_WAIT_DS;
        else if (lane.legal)      state_d = ST_REQ;
        else                      state_d = ST_ERR;
      end
      ST_REQ:     state_d = ST_ACK;
      ST_ACK,
      ST_ERR:     if (ds_s == 2'b11) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q   <= ST_IDLE;
      as_prev_q <= 1'b1;
      idx_q     <= '0;
      write_q   <= 1'b1;
      a1_q      <= 1'b0;
      lword_q   <= 1'b0;
      am_q      <= '0;
      code_q    <= '1;
      wbus_q    <= '0;
      rd_q      <= '0;
    end else begin
      state_q   <= state_d;
      as_prev_q <= as_s;
      if (hdr_le) begin
        idx_q   <= vme_addr[WIN_BITS-1:2];
        write_q <= ~vme_write_n;
        a1_q    <= vme_addr[1];
        lword_q <= vme_lword_n;
        am_q    <= vme_am;
      end
      if (code_le) begin
        code_q  <= code_sel;
        wbus_q  <= vme_data_i;
      end
      if (rd_le) begin
        rd_q    <= reg_rdata;
      end
    end
  end

  // outputs
  assign reg_req       = (state_q == ST_REQ);
  assign reg_we        = write_q;
  assign reg_idx       = idx_q;
  assign reg_be        = lane.be;
  assign reg_wdata     = word_wr;
  assign vme_dtack_low = (state_q == ST_ACK);
  assign vme_berr_low  = (state_q == ST_ERR);
  assign vme_data_oe   = (state_q == ST_ACK) && !write_q;
  assign vme_data_o    = bus_rd;

endmodule

// File: rtl/vme_resp_checker.sv
module vme_resp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       dtack_low,
  input logic       berr_low,
  input logic       data_oe,
  input logic       reg_req,
  input logic [3:0] reg_be,
  input logic [5:0] am_q,
  input logic [1:0] ds_s
);

  // R8: acknowledge and bus error never together
  a_r8_ack_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(dtack_low && berr_low));

  // R8: read data only driven while acknowledging
  a_r8_data_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> dtack_low);

  // R10: local strobe lasts one cycle
  a_r10_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |=> !reg_req);

  // R1: local access only for a served modifier
  a_r1_req_am_served: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> (am_q == 6'h09 || am_q == 6'h39 || am_q == 6'h29));

  // R7: no local access while signalling a bus error
  a_r7_err_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    berr_low |-> !reg_req);

  // R4: a local access always enables at least one byte
  a_r4_be_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> (reg_be != 4'b0000));

  // R9: acknowledge drops only after both synced data strobes were high
  a_r9_release_on_ds: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_low) |-> ($past(ds_s) == 2'b11));

endmodule

bind vme_slave_responder vme_resp_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dtack_low(vme_dtack_low),
  .berr_low (vme_berr_low),
  .data_oe  (vme_data_oe),
  .reg_req  (reg_req),
  .reg_be   (reg_be),
  .am_q     (am_q),
  .ds_s     (ds_s)
);

// File: tb/test_vme_slave_responder.sv
module test_vme_slave_responder;

  localparam int          CLK_PERIOD = 10;
  localparam int          WIN        = 8;
  localparam int          NWORDS     = 1 << (WIN - 2);
  localparam logic [15:0] B16        = 16'hC300;
  localparam logic [23:0] B24        = 24'h5A_0000;
  localparam logic [31:0] B32        = 32'h4200_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        vme_as_n, vme_write_n, vme_lword_n;
  logic [1:0]  vme_ds_n;
  logic [5:0]  vme_am;
  logic [31:1] vme_addr;
  logic [31:0] vme_data_i, vme_data_o;
  logic        vme_data_oe, vme_dtack_low, vme_berr_low;
  logic        reg_req, reg_we;
  logic [WIN-3:0] reg_idx;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata, reg_rdata;

  int n_chk = 0;
  int n_bad = 0;
  int req_seen = 0;

  logic [31:0] mem    [NWORDS];
  logic [31:0] shadow [NWORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  vme_slave_responder #(
    .WIN_BITS(WIN), .BASE_A16(B16), .BASE_A24(B24), .BASE_A32(B32), .SYNC_STAGES(2)
  ) i_vme_slave_responder (
    .clk(clk), .rst_n(rst_n),
    .vme_as_n(vme_as_n), .vme_ds_n(vme_ds_n), .vme_write_n(vme_write_n),
    .vme_lword_n(vme_lword_n), .vme_am(vme_am), .vme_addr(vme_addr),
    .vme_data_i(vme_data_i), .vme_data_o(vme_data_o), .vme_data_oe(vme_data_oe),
    .vme_dtack_low(vme_dtack_low), .vme_berr_low(vme_berr_low),
    .reg_req(reg_req), .reg_we(reg_we), .reg_idx(reg_idx), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [31:0] init_word(int i);
    return 32'hA5C3_0F00 ^ (32'(i) * 32'h0101_0101);
  endfunction

  // local register file behind the port
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= init_word(i);
    end else if (reg_req && reg_we) begin
      for (int b = 0; b < 4; b++)
        if (reg_be[b]) mem[reg_idx][8*b +: 8] <= reg_wdata[8*b +: 8];
    end
  end
  assign reg_rdata = mem[reg_idx];

  always @(negedge clk) if (reg_req) req_seen++;

  function automatic bit lane_ok(logic [3:0] c);
    return (c == 4'b0101 || c == 4'b1001 || c == 4'b0111 || c == 4'b1011 ||
            c == 4'b0001 || c == 4'b0011 || c == 4'b0000);
  endfunction

  function automatic logic [31:0] exp_bus(logic [31:0] w, logic [3:0] c);
    case (c)
      4'b0101: return {16'h0, w[31:24], 8'h0};
      4'b1001: return {24'h0, w[23:16]};
      4'b0111: return {16'h0, w[15:8], 8'h0};
      4'b1011: return {24'h0, w[7:0]};
      4'b0001: return {16'h0, w[31:16]};
      4'b0011: return {16'h0, w[15:0]};
      default: return w;
    endcase
  endfunction

  function automatic logic [31:0] exp_merge(logic [31:0] o, logic [3:0] c, logic [31:0] d);
    logic [31:0] r = o;
    case (c)
      4'b0101: r[31:24] = d[15:8];
      4'b1001: r[23:16] = d[7:0];
      4'b0111: r[15:8]  = d[15:8];
      4'b1011: r[7:0]   = d[7:0];
      4'b0001: r[31:16] = d[15:0];
      4'b0011: r[15:0]  = d[15:0];
      default: r        = d;
    endcase
    return r;
  endfunction

  // sp: 0 = 16-bit space, 1 = 24-bit, 2 = 32-bit
  function automatic logic [5:0] am_of(int sp);
    return (sp == 0) ? 6'h29 : (sp == 1) ? 6'h39 : 6'h09;
  endfunction

  function automatic logic [31:0] mk_addr(int sp, logic [5:0] idx, bit miss);
    logic [31:0] a = $urandom();
    int w;
    a[WIN-1:0] = {idx, 2'b00};
    if (sp == 2)      begin a[31:WIN] = B32[31:WIN]; w = 32 - WIN; end
    else if (sp == 1) begin a[23:WIN] = B24[23:WIN]; w = 24 - WIN; end
    else              begin a[15:WIN] = B16[15:WIN]; w = 16 - WIN; end
    if (miss) begin
      int p = WIN + int'($urandom % 32'(w));
      a[p] = ~a[p];
    end
    return a;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_cycle(logic [5:0] am, logic [31:0] a, bit wr, logic [3:0] code, bit hit);
    logic [5:0]  idx = a[WIN-1:2];
    logic [31:0] wd  = $urandom();
    int r0, k, m;
    bit resp;
    @(negedge clk);
    vme_am = am; vme_addr = a[31:1]; vme_addr[1] = code[1];
    vme_lword_n = code[0]; vme_write_n = !wr; vme_data_i = wd;
    @(negedge clk);
    vme_as_n = 1'b0;
    repeat (6) @(negedge clk);
    r0 = req_seen;
    vme_ds_n = code[3:2];
    k = 0;
    while (k < 12 && !(vme_dtack_low || vme_berr_low)) begin @(negedge clk); k++; end
    resp = vme_dtack_low || vme_berr_low;
    if (!hit) begin
      check(!resp, "R1/R2", "unexpected response", 32'(resp), 0);
      check(req_seen == r0, "R1/R2", "reg_req count", 32'(req_seen - r0), 0);
    end else if (!lane_ok(code)) begin
      check(vme_berr_low && k == 4, "R7", "berr latency", 32'(k), 4);
      check(req_seen == r0, "R7", "reg_req on error", 32'(req_seen - r0), 0);
    end else begin
      check(vme_dtack_low && k == 5, "R8", "dtack latency", 32'(k), 5);
      check(req_seen == r0 + 1, "R10", "reg_req count", 32'(req_seen - r0), 1);
      if (!wr) begin
        check(vme_data_oe, "R8", "data_oe with dtack", 32'(vme_data_oe), 1);
        check(vme_data_o == exp_bus(shadow[idx], code), "R4/R5/R3", "read bus data",
              vme_data_o, exp_bus(shadow[idx], code));
      end else begin
        check(!vme_data_oe, "R8", "no drive on write", 32'(vme_data_oe), 0);
        shadow[idx] = exp_merge(shadow[idx], code, wd);
      end
    end
    vme_ds_n = 2'b11;
    if (resp) begin
      m = 0;
      while (m < 8 && (vme_dtack_low || vme_berr_low || vme_data_oe)) begin
        @(negedge clk); m++;
      end
      check(m == 3, "R9", "release latency", 32'(m), 3);
    end
    vme_as_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // watchdog
  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] codes [7] = '{4'b0101, 4'b1001, 4'b0111, 4'b1011, 4'b0001, 4'b0011, 4'b0000};
    logic [5:0] bad_am [4] = '{6'h0B, 6'h3B, 6'h08, 6'h38};
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    vme_as_n = 1'b1; vme_ds_n = 2'b11; vme_write_n = 1'b1; vme_lword_n = 1'b1;
    vme_am = 6'h09; vme_addr = '0; vme_data_i = '0;
    for (int i = 0; i < NWORDS; i++) shadow[i] = init_word(i);
    repeat (3) @(negedge clk);
    vme_as_n = 1'b0; vme_ds_n = 2'b00; vme_addr = B32[31:1];
    repeat (3) @(negedge clk);
    // R11: nothing active during reset even with strobes low
    check(!vme_dtack_low && !vme_berr_low && !vme_data_oe && !reg_req, "R11", "reset quiet",
          {28'h0, vme_dtack_low, vme_berr_low, vme_data_oe, reg_req}, 0);
    vme_as_n = 1'b1; vme_ds_n = 2'b11;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!vme_dtack_low && !vme_berr_low && !reg_req, "R11", "idle after reset",
          {29'h0, vme_dtack_low, vme_berr_low, reg_req}, 0);

    // every space, every legal lane code: write then full-word read back (R3, R4, R6)
    for (int sp = 0; sp < 3; sp++) begin
      for (int c = 0; c < 7; c++) begin
        logic [5:0] idx = 6'($urandom);
        run_cycle(am_of(sp), mk_addr(sp, idx, 1'b0), 1'b1, codes[c], 1'b1);
        run_cycle(am_of(sp), mk_addr(sp, idx, 1'b0), 1'b0, 4'b0000, 1'b1); // R6 readback
        run_cycle(am_of(sp), mk_addr(sp, idx, 1'b0), 1'b0, codes[c], 1'b1); // R5 lane read
      end
    end
    // R1: unsupported modifiers with matching addresses
    for (int i = 0; i < 4; i++)
      run_cycle(bad_am[i], mk_addr((i % 2 == 0) ? 2 : 1, 6'($urandom), 1'b0), 1'b0, 4'b0000, 1'b0);
    // R2: address mismatch in each space
    for (int sp = 0; sp < 3; sp++)
      run_cycle(am_of(sp), mk_addr(sp, 6'($urandom), 1'b1), 1'b1, 4'b0000, 1'b0);
    // R7: long-word low with A1 high, and other illegal codes
    run_cycle(6'h09, mk_addr(2, 6'd5, 1'b0), 1'b0, 4'b0010, 1'b1);
    run_cycle(6'h29, mk_addr(0, 6'd9, 1'b0), 1'b1, 4'b1000, 1'b1);
    run_cycle(6'h29, mk_addr(0, 6'd9, 1'b0), 1'b0, 4'b0000, 1'b1);

    // constrained random mix
    for (int t = 0; t < 250; t++) begin
      int sel = int'($urandom % 10);
      int sp  = int'($urandom % 3);
      logic [5:0] idx = 6'($urandom);
      logic [3:0] code = ($urandom % 5 == 0) ? 4'($urandom % 12) : codes[$urandom % 7];
      bit wr = 1'($urandom);
      if (sel < 7)
        run_cycle(am_of(sp), mk_addr(sp, idx, 1'b0), wr, code, 1'b1);
      else if (sel == 7)
        run_cycle(bad_am[$urandom % 4], mk_addr(sp, idx, 1'b0), wr, code, 1'b0);
      else if (sel == 8)
        run_cycle(am_of(sp), mk_addr(sp, idx, 1'b1), wr, code, 1'b0);
      else begin
        logic [5:0] am = 6'($urandom);
        bit ok = (am == 6'h09 || am == 6'h39 || am == 6'h29);
        int s2 = (am == 6'h29) ? 0 : (am == 6'h39) ? 1 : 2;
        run_cycle(am, mk_addr(s2, idx, 1'b0), wr, code, ok);
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule